// File: doc/BRIEF.md
# Byte/Word Bus Access Decoder

This block sits on the data port of a 16-bit processor and routes every access to one of four address regions: a small control-register window, a byte-wide device window, a word-wide device window, and a local RAM. Each region has its own rule for access width. The control and byte-device windows take byte accesses only. The word-device window takes word accesses only. The RAM takes either width. Word accesses must also sit on even addresses. An access that breaks any of these rules is blocked and reported on a one-cycle fault pulse.

Data is little-endian. In a word, the even byte address holds bits 7:0 and the odd address holds bits 15:8. A byte write places the byte on the lane picked by address bit 0. A byte read returns the picked lane in bits 7:0, with bits 15:8 cleared.

The device windows are reached through one-hot select lines. These selects are asserted combinationally in the strobe cycle, and the devices decode `addr` themselves. The RAM is held inside the block and has per-lane write enables. All read data, and the fault pulse, appear one cycle after the strobe.

Top module: `bus_width_decoder`

## Requirements
- R1: The control window 0x0000–0x000F accepts byte accesses only. A word access or fetch there raises a fault and asserts no select.
- R2: The byte-device window 0x0010–0x00FF accepts byte accesses only. A word access or fetch there raises a fault.
- R3: The word-device window 0x0100–0x01FF accepts only word accesses at even addresses. A byte access there raises a fault.
- R4: RAM occupies 0x0200 up to 0x0200+RAM_BYTES-1 and accepts both widths. Any address at or above 0x0200+RAM_BYTES is unmapped and raises a fault.
- R5: A word access or fetch with address bit 0 set raises a fault. A fetch (fetch_en) is always treated as a word read, whatever is_word says.
- R6: A word write stores wdata[7:0] at the even byte and wdata[15:8] at the odd byte. A byte write changes only the byte at its address, using wdata[7:0].
- R7: Read data appears on rdata in the cycle after the strobe. In any cycle that follows a cycle with no accepted read, rdata is 0x0000.
- R8: A byte read returns the addressed byte in bits 7:0 and 0x00 in bits 15:8. The byte comes from lane 15:8 when the address is odd and from lane 7:0 when it is even.
- R9: A faulting access changes no RAM byte and drives no device select. It yields rdata = 0x0000 and fault = 1 in the next cycle only.
- R10: At most one device select is high at a time. per_we marks an accepted device write. per_be is 2'b11 for a word, 2'b01 for an even byte and 2'b10 for an odd byte, and 2'b00 when no device is selected. On a byte write, per_wdata carries the byte on its lane, with zeros on the other lane.
- R11: A write strobe asserted together with a read or fetch strobe raises a fault.
- R12: During and right after reset, rdata is 0x0000 and fault is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Byte address of the access |
| is_word | input | 1 | 1 = word access, 0 = byte access |
| rd_en | input | 1 | Data read strobe |
| wr_en | input | 1 | Write strobe |
| fetch_en | input | 1 | Instruction fetch strobe (word read) |
| wdata | input | 16 | Write data; byte writes use bits 7:0 |
| rdata | output | 16 | Read data, one cycle after the strobe |
| fault | output | 1 | One-cycle pulse after a rejected access |
| ctrl_sel | output | 1 | Control-window select |
| bdev_sel | output | 1 | Byte-device window select |
| wdev_sel | output | 1 | Word-device window select |
| per_we | output | 1 | Device write enable |
| per_be | output | 2 | Device byte-lane enables |
| per_wdata | output | 16 | Lane-steered device write data |
| per_rdata | input | 16 | Device read data, valid in the strobe cycle |

## Verification
The hardest condition to bring about is a faulting write aimed at RAM. Its only possible harm is a RAM byte that changes, and that change cannot be seen on any port until a later read reaches the same word. To catch it, the bench first fills the whole RAM with known words. It then sends odd-address word writes, writes that collide with a read strobe, and writes one past the RAM top. After each of these it reads the neighbouring words back. The long pseudo-random phase keeps mixing byte writes, word writes and rejected writes across a small set of RAM words. Any stray lane update therefore shows up in a later comparison against the bench's byte-level memory model.

// File: rtl/bwd_pkg.sv
// Package: shared region encoding and fixed window limits for the decoder.
// Assumes a 16-bit byte address; the limits are exclusive upper bounds.
package bwd_pkg;
    typedef enum logic [2:0] {
        RG_CTRL = 3'd0,
        RG_BDEV = 3'd1,
        RG_WDEV = 3'd2,
        RG_RAM  = 3'd3,
        RG_NONE = 3'd4
    } region_e;

    localparam int unsigned CTRL_LIMIT = 32'h0010;
    localparam int unsigned BDEV_LIMIT = 32'h0100;
    localparam int unsigned WDEV_LIMIT = 32'h0200;
    localparam int unsigned RAM_BASE   = 32'h0200;
endpackage

// File: rtl/bwd_region_decode.sv
// Module: bwd_region_decode
// Purely combinational. Classifies the address into a region, checks
// the access width and alignment against that region's rule, and reports
// whether the access is granted or faulted. Assumes at most one access per cycle.
module bwd_region_decode
    import bwd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int RAM_BYTES = 512
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_word,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              fetch_en,
    output region_e           region,
    output logic              wide,
    output logic              access,
    output logic              grant,
    output logic              flt
);
    localparam logic [ADDR_W:0] RAM_END = (ADDR_W+1)'(RAM_BASE + RAM_BYTES);

    logic width_ok;
    logic misalign;
    logic conflict;

    // Address-range classification.
    always_comb begin
        if ({1'b0, addr} < (ADDR_W+1)'(CTRL_LIMIT))      region = RG_CTRL;
        else if ({1'b0, addr} < (ADDR_W+1)'(BDEV_LIMIT)) region = RG_BDEV;
        else if ({1'b0, addr} < (ADDR_W+1)'(WDEV_LIMIT)) region = RG_WDEV;
        else if ({1'b0, addr} < RAM_END)                 region = RG_RAM;
        else                                             region = RG_NONE;
    end

    // Width legality per region; fetches count as word accesses.
    always_comb begin
        wide = is_word | fetch_en;
        unique case (region)
            RG_CTRL, RG_BDEV: width_ok = ~wide;
            RG_WDEV:          width_ok = wide;
            RG_RAM:           width_ok = 1'b1;
            default:          width_ok = 1'b0;
        endcase
    end

    // Fault and grant resolution.
    always_comb begin
        access   = rd_en | wr_en | fetch_en;
        misalign = wide & addr[0];
        conflict = wr_en & (rd_en | fetch_en);
        flt      = access & (~width_ok | misalign | conflict);
        grant    = access & ~flt;
    end
endmodule

// File: rtl/bwd_lane_ram.sv
// Module: bwd_lane_ram
// Word-organised RAM built from two byte lanes, each with its own write
// enable. The read is synchronous with one cycle of latency. The contents
// are not reset; the caller must qualify the read data with its own valid flag.
module bwd_lane_ram #(
    parameter int WORDS = 256,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       be,
    input  logic [15:0]      wd,
    output logic [15:0]      rd
);
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [7:0] mem [WORDS];

        // Per-lane write and registered read.
        always_ff @(posedge clk) begin
            if (we && be[g]) mem[idx] <= wd[8*g +: 8];
            if (re)          rd[8*g +: 8] <= mem[idx];
        end
    end
endmodule

// File: rtl/bwd_read_format.sv
// Module: bwd_read_format
// Combinational read-return shaping. Picks RAM or device data, extracts
// the addressed byte for narrow reads, zero-extends it, and forces 0x0000
// when no read was accepted. All inputs are registered by the caller.
module bwd_read_format (
    input  logic        valid_q,
    input  logic        from_ram_q,
    input  logic        narrow_q,
    input  logic        odd_q,
    input  logic [15:0] ram_d,
    input  logic [15:0] dev_d,
    output logic [15:0] rdata
);
    logic [15:0] src;

    // Source selection and byte extraction.
    always_comb begin
        src = from_ram_q ? ram_d : dev_d;
        if (!valid_q)      rdata = 16'h0000;
        else if (narrow_q) rdata = {8'h00, (odd_q ? src[15:8] : src[7:0])};
        else               rdata = src;
    end
endmodule

// File: rtl/bus_width_decoder.sv
// Module: bus_width_decoder
// Top level. Decodes each processor access and steers bytes little-endian
// onto the RAM lanes or the device bus. Rejected accesses are blocked, and
// read data and the fault pulse are returned one cycle after the strobe.
// Assumes per_rdata is valid combinationally during the strobe cycle.
module bus_width_decoder
    import bwd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int RAM_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_word,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              fetch_en,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              fault,
    output logic              ctrl_sel,
    output logic              bdev_sel,
    output logic              wdev_sel,
    output logic              per_we,
    output logic [1:0]        per_be,
    output logic [15:0]       per_wdata,
    input  logic [15:0]       per_rdata
);
    localparam int WORDS = RAM_BYTES / 2;
    localparam int IDX_W = $clog2(WORDS);
    localparam logic [ADDR_W-1:0] RAM_BASE_A = ADDR_W'(RAM_BASE);

    region_e          region;
    logic             wide, access, grant, flt;
    logic             is_dev, rd_go, ram_we, ram_re;
    logic [1:0]       lane_be;
    logic [15:0]      lane_wd;
    logic [IDX_W-1:0] ram_idx;
    logic [15:0]      ram_rd;

    logic             valid_q, from_ram_q, narrow_q, odd_q, fault_q;
    logic [15:0]      dev_q;

    bwd_region_decode #(.ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES)) u_dec (
        .addr(addr), .is_word(is_word), .rd_en(rd_en), .wr_en(wr_en),
        .fetch_en(fetch_en), .region(region), .wide(wide), .access(access),
        .grant(grant), .flt(flt)
    );

    // Lane enables and little-endian write-data steering.
    always_comb begin
        if (wide) begin
            lane_be = 2'b11;
            lane_wd = wdata;
        end else if (addr[0]) begin
            lane_be = 2'b10;
            lane_wd = {wdata[7:0], 8'h00};
        end else begin
            lane_be = 2'b01;
            lane_wd = {8'h00, wdata[7:0]};
        end
    end

    // Strobe qualification for RAM and device targets.
    always_comb begin
        is_dev  = (region == RG_CTRL) | (region == RG_BDEV) | (region == RG_WDEV);
        rd_go   = grant & (rd_en | fetch_en);
        ram_we  = grant & wr_en & (region == RG_RAM);
        ram_re  = rd_go & (region == RG_RAM);
        ram_idx = IDX_W'((addr - RAM_BASE_A) >> 1);
    end

    // Device-side select and write outputs.
    always_comb begin
        ctrl_sel  = grant & (region == RG_CTRL);
        bdev_sel  = grant & (region == RG_BDEV);
        wdev_sel  = grant & (region == RG_WDEV);
        per_we    = grant & wr_en & is_dev;
        per_be    = (grant & is_dev) ? lane_be : 2'b00;
        per_wdata = lane_wd;
    end

    bwd_lane_ram #(.WORDS(WORDS), .IDX_W(IDX_W)) u_ram (
        .clk(clk), .we(ram_we), .re(ram_re), .idx(ram_idx),
        .be(lane_be), .wd(lane_wd), .rd(ram_rd)
    );

    // Response pipeline: read context, captured device data, fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q    <= 1'b0;
            from_ram_q <= 1'b0;
            narrow_q   <= 1'b0;
            odd_q      <= 1'b0;
            fault_q    <= 1'b0;
            dev_q      <= 16'h0000;
        end else begin
            valid_q    <= rd_go;
            from_ram_q <= (region == RG_RAM);
            narrow_q   <= ~wide;
            odd_q      <= addr[0];
            fault_q    <= flt;
            if (rd_go && is_dev) dev_q <= per_rdata;
        end
    end

    bwd_read_format u_fmt (
        .valid_q(valid_q), .from_ram_q(from_ram_q), .narrow_q(narrow_q),
        .odd_q(odd_q), .ram_d(ram_rd), .dev_d(dev_q), .rdata(rdata)
    );

    assign fault = fault_q;

    // Word-sized access on an odd address is flagged next cycle.
    assert_word_odd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en | wr_en | fetch_en) && (is_word | fetch_en) && addr[0]) |=> fault);

    // Simultaneous write and read/fetch is rejected.
    assert_conflict_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (rd_en | fetch_en)) |=> fault);

    // A fault pulse always comes with zero read data.
    assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (rdata == 16'h0000));

    // Device selects are mutually exclusive.
    assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_sel, bdev_sel, wdev_sel}));

    // Control window only ever selected for byte accesses.
    assert_ctrl_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_sel |-> !(is_word | fetch_en));

    // Word-device window only selected for even word accesses.
    assert_wdev_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wdev_sel |-> ((is_word | fetch_en) && !addr[0]));

    // Byte reads return an empty upper byte.
    assert_byte_zext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !is_word && !wr_en && !fetch_en) |=> (rdata[15:8] == 8'h00));

    // Without a read strobe, the next cycle returns zero.
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en | fetch_en) |=> (rdata == 16'h0000));
endmodule

// File: tb/sim_bus_width_decoder.sv
`timescale 1ns/1ps
// Bench: behavioural byte-level reference model, compared every clock.
module sim_bus_width_decoder;
    localparam int RAM_BYTES = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        is_word = 1'b0, rd_en = 1'b0, wr_en = 1'b0, fetch_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata, per_wdata, per_rdata;
    logic        fault, ctrl_sel, bdev_sel, wdev_sel, per_we;
    logic [1:0]  per_be;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0]  mem [RAM_BYTES];
    logic [15:0] exp_rd = 16'h0;
    bit          exp_flt = 0;
    bit          exp_narrow = 0;

    always #2.5 clk = ~clk;

    assign per_rdata = {addr[7:0] ^ 8'hC3, addr[15:8] ^ addr[7:0] ^ 8'h3C};

    bus_width_decoder #(.ADDR_W(16), .RAM_BYTES(RAM_BYTES)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .is_word(is_word),
        .rd_en(rd_en), .wr_en(wr_en), .fetch_en(fetch_en), .wdata(wdata),
        .rdata(rdata), .fault(fault), .ctrl_sel(ctrl_sel), .bdev_sel(bdev_sel),
        .wdev_sel(wdev_sel), .per_we(per_we), .per_be(per_be),
        .per_wdata(per_wdata), .per_rdata(per_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic int region_of(input int a);
        if (a < 16)              return 0;
        if (a < 256)             return 1;
        if (a < 512)             return 2;
        if (a < 512 + RAM_BYTES) return 3;
        return 4;
    endfunction

    function automatic logic [15:0] dev_fn(input int a);
        logic [15:0] x = a[15:0];
        return {x[7:0] ^ 8'hC3, x[15:8] ^ x[7:0] ^ 8'h3C};
    endfunction

    // Compare last cycle's response, drive a new access, check the device side.
    task automatic cyc(input bit r, input bit w, input bit f, input bit isw,
                       input int a, input logic [15:0] d);
        bit acc, wide, okw, flt, gr;
        int rg, off;
        logic [15:0] ld, src;
        logic [1:0]  be;
        @(negedge clk);
        chk(fault == exp_flt, "R9 fault", {15'h0, fault}, {15'h0, exp_flt});
        chk(rdata == exp_rd, exp_flt ? "R9 rdata" : (exp_narrow ? "R8 rdata" : "R7 rdata"),
            rdata, exp_rd);
        rd_en = r; wr_en = w; fetch_en = f; is_word = isw; addr = a[15:0]; wdata = d;
        #1;
        acc  = r | w | f;
        wide = isw | f;
        rg   = region_of(a);
        okw  = (rg <= 1) ? !wide : (rg == 2) ? wide : (rg == 3);
        flt  = acc && (!okw || (wide && a[0]) || (w && (r || f)));
        gr   = acc && !flt;
        be   = wide ? 2'b11 : (a[0] ? 2'b10 : 2'b01);
        ld   = wide ? d : (a[0] ? {d[7:0], 8'h00} : {8'h00, d[7:0]});
        chk(ctrl_sel == (gr && rg == 0), "R10 ctrl_sel", {15'h0, ctrl_sel}, {15'h0, gr && rg == 0});
        chk(bdev_sel == (gr && rg == 1), "R10 bdev_sel", {15'h0, bdev_sel}, {15'h0, gr && rg == 1});
        chk(wdev_sel == (gr && rg == 2), "R10 wdev_sel", {15'h0, wdev_sel}, {15'h0, gr && rg == 2});
        chk(per_we == (gr && w && rg < 3), "R10 per_we", {15'h0, per_we}, {15'h0, gr && w && rg < 3});
        chk(per_be == ((gr && rg < 3) ? be : 2'b00), "R10 per_be", {14'h0, per_be},
            {14'h0, ((gr && rg < 3) ? be : 2'b00)});
        if (gr && w && rg < 3) chk(per_wdata == ld, "R10 per_wdata", per_wdata, ld);
        exp_flt = flt;
        exp_narrow = !wide;
        exp_rd = 16'h0;
        off = (a - 512) & ~1;
        if (gr && (r || f)) begin
            src = (rg == 3) ? {mem[off + 1], mem[off]} : dev_fn(a);
            exp_rd = wide ? src : {8'h00, (a[0] ? src[15:8] : src[7:0])};
        end
        if (gr && w && rg == 3) begin
            if (be[0]) mem[off]     = ld[7:0];
            if (be[1]) mem[off + 1] = ld[15:8];
        end
    endtask

    initial begin
        logic [31:0] seed = 32'h1234_5678;
        // R12: reset state.
        repeat (3) begin
            @(negedge clk);
            chk(rdata == 16'h0 && fault == 1'b0, "R12 reset", rdata, 16'h0);
        end
        rst_n = 1'b1;
        // R4/R6: fill RAM with known words.
        for (int i = 0; i < RAM_BYTES / 2; i++)
            cyc(0, 1, 0, 1, 512 + 2 * i, 16'hA000 ^ i[15:0] * 16'h0107);
        cyc(1, 0, 0, 1, 512, 0);                  // R7 word read
        cyc(0, 1, 0, 0, 513, 16'h55AB);           // R6 odd byte write
        cyc(1, 0, 0, 1, 512, 0);                  // R6 lanes
        cyc(1, 0, 0, 0, 513, 0);                  // R8 odd byte
        cyc(1, 0, 0, 0, 512, 0);                  // R8 even byte
        cyc(0, 1, 0, 1, 515, 16'hDEAD);           // R5 misaligned write, R9
        cyc(1, 0, 0, 1, 514, 0);                  // R9 unchanged
        cyc(0, 0, 1, 1, 517, 0);                  // R5 odd fetch
        cyc(0, 0, 1, 0, 516, 0);                  // R5 fetch is word
        cyc(1, 0, 0, 0, 5, 0);                    // R1 byte ok
        cyc(0, 1, 0, 0, 14, 16'h0077);            // R1 byte write
        cyc(1, 0, 0, 1, 4, 0);                    // R1 word fault
        cyc(1, 0, 0, 0, 255, 0);                  // R2 byte ok
        cyc(0, 1, 0, 1, 16, 16'h1234);            // R2 word fault
        cyc(1, 0, 0, 1, 256, 0);                  // R3 word ok
        cyc(0, 1, 0, 1, 510, 16'hBEEF);           // R3 write
        cyc(1, 0, 0, 0, 257, 0);                  // R3 byte fault
        cyc(0, 1, 0, 0, 512 + RAM_BYTES - 1, 16'h00E1); // R4 top byte
        cyc(1, 0, 0, 0, 512 + RAM_BYTES - 1, 0);  // R4
        cyc(0, 1, 0, 1, 512 + RAM_BYTES, 16'h9999);// R4 unmapped
        cyc(1, 0, 0, 1, 16'hFFFE, 0);             // R4 unmapped read
        cyc(1, 1, 0, 1, 520, 16'h4444);           // R11 conflict
        cyc(0, 1, 1, 1, 522, 16'h4444);           // R11 conflict with fetch
        cyc(1, 0, 0, 1, 520, 0);                  // R9 no side effect
        cyc(1, 0, 0, 1, 522, 0);
        cyc(0, 0, 0, 1, 600, 0);                  // R7 idle
        for (int n = 0; n < 4000; n++) begin
            int a;
            bit r, w, f, isw;
            seed = seed * 32'd1103515245 + 32'd12345;
            case (seed[30:28] % 5)
                0: a = int'(seed[19:16]);
                1: a = 16 + int'(seed[23:16]) % 240;
                2: a = 256 + int'(seed[23:16]);
                3: a = 512 + int'(seed[21:16]) + (seed[27] ? RAM_BYTES - 64 : 0);
                default: a = 512 + RAM_BYTES + int'(seed[23:16]) - 4;
            endcase
            r   = seed[10];
            w   = seed[11] & (seed[12] | ~r);
            f   = seed[13] & seed[14];
            isw = seed[15];
            cyc(r, w, f, isw, a, seed[31:16] ^ seed[15:0]);
        end
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule